// File: doc/BRIEF.md
# Video Black-Level and Gain Loop Controller

This block is the digital steering logic for a two-channel video digitiser. Each sample clock it looks at the 8-bit luma code and the 8-bit chroma code from the converters and decides, for three external analog loops, whether to charge, discharge or leave alone the capacitor that sets each loop. The three loops are luma gain, luma black-level clamp and chroma black-level clamp. Two gate pulses tell the block where it is in the line. The sync gate covers the sync tip, and the gain loop uses it to pull the tip to code 1. The porch gate covers the back porch, and both clamp loops use it to pull luma to code 64 and chroma to code 128.

An active-low peak-white enable lets a full-scale luma sample override the gain loop and lower the gain. The block flags overlapping gates as an error. It reports when the sync tip and black level both sit on target, which means the sync amplitude spans 64 codes. It also passes both sample streams out as offset binary or two's complement, selected per channel.

Top module: `vidfe_loop_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every loop command becomes hold (2'b00), `gate_overlap_err` and `levels_locked` become 0, and both data outputs become 0.
- R2: When only the sync gate is high, `gain_cmd` one clock later is discharge (2'b10) if the luma code was above 1, charge (2'b01) if it was below 1, and hold if it was exactly 1.
- R3: When only the porch gate is high, `luma_clamp_cmd` one clock later is discharge if the luma code was above 64, charge if it was below 64, and hold at 64.
- R4: When only the porch gate is high, `chroma_clamp_cmd` one clock later is discharge if the chroma code was above 128, charge if it was below 128, and hold at 128.
- R5: When `peak_white_n` is 0, a luma code of 255 and no gate overlap make `gain_cmd` charge (the gain-lowering direction) one clock later, whether or not the sync gate is high. With `peak_white_n` at 1, a code of 255 has no such effect.
- R6: With both gates low and no peak-white hit, all three commands are hold one clock later.
- R7: If both gates are high in the same cycle, all three commands are hold one clock later and `gate_overlap_err` goes to 1. It stays at 1 until reset.
- R8: One clock after a sample, `luma_out` and `chroma_out` carry that sample's code. The MSB is inverted when the channel's format select (`luma_tc`, `chroma_tc`) was 1, which gives two's complement. The code is unchanged when the select was 0, which gives offset binary.
- R9: `levels_locked` is 1 one clock after the latest non-overlapping sync-gate luma sample was 1 and the latest non-overlapping porch-gate luma sample was 64. Any other sample in either window clears it. While it is high, the black-to-tip span, counted inclusive, is 64 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| luma_code | input | 8 | Luma converter code, offset binary |
| chroma_code | input | 8 | Chroma converter code, offset binary |
| gate_sync | input | 1 | High during the sync tip window |
| gate_porch | input | 1 | High during the back porch window |
| peak_white_n | input | 1 | Active-low peak-white limiter enable |
| luma_tc | input | 1 | 1 selects two's complement for luma output |
| chroma_tc | input | 1 | 1 selects two's complement for chroma output |
| gain_cmd | output | 2 | Luma gain loop command: 00 hold, 01 charge, 10 discharge |
| luma_clamp_cmd | output | 2 | Luma clamp loop command, same coding |
| chroma_clamp_cmd | output | 2 | Chroma clamp loop command, same coding |
| gate_overlap_err | output | 1 | Sticky flag: both gates were seen high together |
| levels_locked | output | 1 | Sync tip and black level both on target |
| luma_out | output | 8 | Formatted luma code, one clock late |
| chroma_out | output | 8 | Formatted chroma code, one clock late |

## Verification
On every cycle the assertions check several properties. Gate overlap forces hold and sets a flag that never drops. Quiet cycles leave every loop on hold, and a peak-white hit always drives the gain loop to charge. Commands never take the unused code, the formatted outputs keep the lower seven bits of the sample, and the lock flag only stands with a 64-code span. Only the bench scenarios show the exact direction chosen on each side of every target and the priority between peak white and the sync gate. They also show how the lock flag is gained and lost across a sequence of gate windows, and that reset clears the sticky error.

// File: rtl/vidfe_pkg.sv
package vidfe_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    CMD_HOLD      = 2'b00,
    CMD_CHARGE    = 2'b01,
    CMD_DISCHARGE = 2'b10
  } loop_cmd_e;

  // direction that moves a sampled code toward its target
  function automatic loop_cmd_e steer(input logic [CODE_W-1:0] code,
                                      input logic [CODE_W-1:0] target);
    if (code > target)      return CMD_DISCHARGE;
    else if (code < target) return CMD_CHARGE;
    else                    return CMD_HOLD;
  endfunction

  // offset binary to two's complement by flipping the sign bit
  function automatic logic [CODE_W-1:0] fmt_code(input logic [CODE_W-1:0] code,
                                                 input logic tc);
    return {code[CODE_W-1] ^ tc, code[CODE_W-2:0]};
  endfunction

  // inclusive code count from sync tip up to black level
  function automatic logic [CODE_W:0] code_span(input logic [CODE_W-1:0] black,
                                                input logic [CODE_W-1:0] tip);
    return {1'b0, black} - {1'b0, tip} + 1'b1;
  endfunction
endpackage

// File: rtl/vidfe_loop_reg.sv
module vidfe_loop_reg
  import vidfe_pkg::*;
#(
  parameter int TARGET = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_en,
  input  logic              force_hold,
  input  logic              force_charge,
  input  logic [CODE_W-1:0] code,
  output loop_cmd_e         cmd
);
  localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET);

  loop_cmd_e cmd_next;

  always_comb begin
    if (force_hold)        cmd_next = CMD_HOLD;
    else if (force_charge) cmd_next = CMD_CHARGE;
    else if (win_en)       cmd_next = steer(code, TGT);
    else                   cmd_next = CMD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) cmd <= CMD_HOLD;
    else     cmd <= cmd_next;
  end

  assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (rst)
    cmd != loop_cmd_e'(2'b11));
endmodule

// File: rtl/vidfe_fmt.sv
module vidfe_fmt
  import vidfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tc,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out
);
  always_ff @(posedge clk) begin
    if (rst) code_out <= '0;
    else     code_out <= fmt_code(code_in, tc);
  end

  assert_low_bits_kept_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> code_out[CODE_W-2:0] == $past(code_in[CODE_W-2:0]));
endmodule

// File: rtl/vidfe_lock_trk.sv
module vidfe_lock_trk
  import vidfe_pkg::*;
#(
  parameter int TIP_CODE   = 1,
  parameter int BLACK_CODE = 64,
  parameter int SPAN_CODES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tip_win,
  input  logic              black_win,
  input  logic [CODE_W-1:0] luma,
  output logic              locked
);
  localparam logic [CODE_W-1:0] TIP_T = CODE_W'(TIP_CODE);
  localparam logic [CODE_W-1:0] BLK_T = CODE_W'(BLACK_CODE);
  localparam logic [CODE_W:0]   SPAN  = (CODE_W+1)'(SPAN_CODES);

  logic              tip_ok, blk_ok;
  logic [CODE_W-1:0] tip_seen, blk_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      tip_ok   <= 1'b0;
      blk_ok   <= 1'b0;
      tip_seen <= '0;
      blk_seen <= '0;
    end else begin
      if (tip_win) begin
        tip_ok   <= (luma == TIP_T);
        tip_seen <= luma;
      end
      if (black_win) begin
        blk_ok   <= (luma == BLK_T);
        blk_seen <= luma;
      end
    end
  end

  assign locked = tip_ok & blk_ok;

  assert_lock_span_R9: assert property (@(posedge clk) disable iff (rst)
    locked |-> code_span(blk_seen, tip_seen) == SPAN);
endmodule

// File: rtl/vidfe_loop_ctrl.sv
module vidfe_loop_ctrl
  import vidfe_pkg::*;
#(
  parameter int SYNC_TARGET   = 1,
  parameter int BLACK_TARGET  = 64,
  parameter int CHROMA_TARGET = 128,
  parameter int SPAN_CODES    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] luma_code,
  input  logic [CODE_W-1:0] chroma_code,
  input  logic              gate_sync,
  input  logic              gate_porch,
  input  logic              peak_white_n,
  input  logic              luma_tc,
  input  logic              chroma_tc,
  output logic [1:0]        gain_cmd,
  output logic [1:0]        luma_clamp_cmd,
  output logic [1:0]        chroma_clamp_cmd,
  output logic              gate_overlap_err,
  output logic              levels_locked,
  output logic [CODE_W-1:0] luma_out,
  output logic [CODE_W-1:0] chroma_out
);
  localparam logic [CODE_W-1:0] FULL_SCALE = '1;

  // named internal events
  logic gate_clash;
  logic pw_hit;
  logic sync_win;
  logic porch_win;
  loop_cmd_e gain_q, lclamp_q, cclamp_q;

  assign gate_clash = gate_sync & gate_porch;
  assign pw_hit     = !peak_white_n && (luma_code == FULL_SCALE);
  assign sync_win   = gate_sync  & ~gate_clash;
  assign porch_win  = gate_porch & ~gate_clash;

  vidfe_loop_reg #(.TARGET(SYNC_TARGET)) u_gain (
    .clk(clk), .rst(rst), .win_en(sync_win), .force_hold(gate_clash),
    .force_charge(pw_hit), .code(luma_code), .cmd(gain_q));

  vidfe_loop_reg #(.TARGET(BLACK_TARGET)) u_lclamp (
    .clk(clk), .rst(rst), .win_en(porch_win), .force_hold(gate_clash),
    .force_charge(1'b0), .code(luma_code), .cmd(lclamp_q));

  vidfe_loop_reg #(.TARGET(CHROMA_TARGET)) u_cclamp (
    .clk(clk), .rst(rst), .win_en(porch_win), .force_hold(gate_clash),
    .force_charge(1'b0), .code(chroma_code), .cmd(cclamp_q));

  assign gain_cmd         = gain_q;
  assign luma_clamp_cmd   = lclamp_q;
  assign chroma_clamp_cmd = cclamp_q;

  always_ff @(posedge clk) begin
    if (rst)             gate_overlap_err <= 1'b0;
    else if (gate_clash) gate_overlap_err <= 1'b1;
  end

  vidfe_lock_trk #(
    .TIP_CODE(SYNC_TARGET), .BLACK_CODE(BLACK_TARGET), .SPAN_CODES(SPAN_CODES)
  ) u_lock (
    .clk(clk), .rst(rst), .tip_win(sync_win), .black_win(porch_win),
    .luma(luma_code), .locked(levels_locked));

  vidfe_fmt u_fmt_y (.clk(clk), .rst(rst), .tc(luma_tc),
    .code_in(luma_code), .code_out(luma_out));
  vidfe_fmt u_fmt_c (.clk(clk), .rst(rst), .tc(chroma_tc),
    .code_in(chroma_code), .code_out(chroma_out));

  assert_clash_holds_R7: assert property (@(posedge clk) disable iff (rst)
    gate_clash |=> (gain_cmd == 2'b00 && luma_clamp_cmd == 2'b00 &&
                    chroma_clamp_cmd == 2'b00 && gate_overlap_err));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    gate_overlap_err |=> gate_overlap_err);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!gate_sync && !gate_porch && !pw_hit) |=>
      (gain_cmd == 2'b00 && luma_clamp_cmd == 2'b00 && chroma_clamp_cmd == 2'b00));

  assert_pw_charge_R5: assert property (@(posedge clk) disable iff (rst)
    (pw_hit && !gate_clash) |=> gain_cmd == 2'b01);
endmodule

// File: tb/vidfe_loop_ctrl_tb.sv
module vidfe_loop_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] luma_code, chroma_code;
  logic       gate_sync, gate_porch, peak_white_n, luma_tc, chroma_tc;
  logic [1:0] gain_cmd, luma_clamp_cmd, chroma_clamp_cmd;
  logic       gate_overlap_err, levels_locked;
  logic [7:0] luma_out, chroma_out;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidfe_loop_ctrl u_dut (
    .clk(clk), .rst(rst), .luma_code(luma_code), .chroma_code(chroma_code),
    .gate_sync(gate_sync), .gate_porch(gate_porch), .peak_white_n(peak_white_n),
    .luma_tc(luma_tc), .chroma_tc(chroma_tc), .gain_cmd(gain_cmd),
    .luma_clamp_cmd(luma_clamp_cmd), .chroma_clamp_cmd(chroma_clamp_cmd),
    .gate_overlap_err(gate_overlap_err), .levels_locked(levels_locked),
    .luma_out(luma_out), .chroma_out(chroma_out));

  function automatic logic [1:0] want_dir(input int code, input int target);
    if (code > target) return 2'b10;
    if (code < target) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply one cycle of inputs at negedge, sample just after the next posedge
  task automatic cycle(input logic gs, input logic gp, input logic pwn,
                       input int y, input int c);
    @(negedge clk);
    gate_sync = gs; gate_porch = gp; peak_white_n = pwn;
    luma_code = 8'(y); chroma_code = 8'(c);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gate_sync = 0; gate_porch = 0; peak_white_n = 1;
    luma_code = 0; chroma_code = 0; luma_tc = 0; chroma_tc = 0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    cycle(1, 0, 1, 200, 50);
    cycle(1, 1, 1, 200, 50);
    do_reset();
    #1;
    check("R1 gain", gain_cmd, 0);
    check("R1 lclamp", luma_clamp_cmd, 0);
    check("R1 cclamp", chroma_clamp_cmd, 0);
    check("R1 err", gate_overlap_err, 0);
    check("R1 lock", levels_locked, 0);
    check("R1 yout", luma_out, 0);
    check("R1 cout", chroma_out, 0);
  endtask

  task automatic t_gain();
    int codes[4] = '{0, 1, 5, 200};
    foreach (codes[i]) begin
      cycle(1, 0, 1, codes[i], 128);
      check("R2 gain", gain_cmd, want_dir(codes[i], 1));
      check("R2 clamp idle", luma_clamp_cmd, 0);
    end
  endtask

  task automatic t_clamp();
    int ys[4] = '{64, 10, 100, 63};
    int cs[4] = '{128, 0, 255, 129};
    foreach (ys[i]) begin
      cycle(0, 1, 1, ys[i], cs[i]);
      check("R3 luma clamp", luma_clamp_cmd, want_dir(ys[i], 64));
      check("R4 chroma clamp", chroma_clamp_cmd, want_dir(cs[i], 128));
      check("R3 gain idle", gain_cmd, 0);
    end
  endtask

  task automatic t_peak();
    cycle(1, 0, 0, 255, 128);
    check("R5 pw over sync gate", gain_cmd, 1);
    cycle(0, 0, 0, 255, 128);
    check("R5 pw no gate", gain_cmd, 1);
    cycle(1, 0, 1, 255, 128);
    check("R5 pw disabled", gain_cmd, 2);
    cycle(0, 0, 0, 254, 128);
    check("R5 below full scale", gain_cmd, 0);
  endtask

  task automatic t_idle();
    cycle(1, 0, 1, 9, 3);
    cycle(0, 0, 1, 9, 3);
    check("R6 gain", gain_cmd, 0);
    check("R6 lclamp", luma_clamp_cmd, 0);
    check("R6 cclamp", chroma_clamp_cmd, 0);
  endtask

  task automatic t_overlap();
    check("R7 err clear before", gate_overlap_err, 0);
    cycle(1, 1, 0, 255, 3);
    check("R7 gain hold", gain_cmd, 0);
    check("R7 lclamp hold", luma_clamp_cmd, 0);
    check("R7 cclamp hold", chroma_clamp_cmd, 0);
    check("R7 err set", gate_overlap_err, 1);
    cycle(0, 0, 1, 0, 0);
    cycle(0, 1, 1, 0, 0);
    check("R7 err sticky", gate_overlap_err, 1);
    do_reset();
    #1;
    check("R7 err cleared by reset", gate_overlap_err, 0);
  endtask

  task automatic t_format();
    @(negedge clk); luma_tc = 1; chroma_tc = 0;
    cycle(0, 0, 1, 8'h90, 8'h35);
    check("R8 luma tc", luma_out, 8'h10);
    check("R8 chroma ob", chroma_out, 8'h35);
    @(negedge clk); luma_tc = 0; chroma_tc = 1;
    cycle(0, 0, 1, 8'h22, 8'h05);
    check("R8 luma ob", luma_out, 8'h22);
    check("R8 chroma tc", chroma_out, 8'h85);
    @(negedge clk); luma_tc = 0; chroma_tc = 0;
  endtask

  task automatic t_lock();
    do_reset();
    cycle(1, 0, 1, 1, 128);
    check("R9 tip only", levels_locked, 0);
    cycle(0, 1, 1, 64, 128);
    check("R9 locked", levels_locked, 1);
    cycle(0, 0, 1, 200, 128);
    check("R9 held outside windows", levels_locked, 1);
    cycle(1, 1, 1, 7, 128);
    check("R9 overlap ignored", levels_locked, 1);
    cycle(0, 1, 1, 65, 128);
    check("R9 black off", levels_locked, 0);
    cycle(0, 1, 1, 64, 128);
    check("R9 relock", levels_locked, 1);
    cycle(1, 0, 1, 2, 128);
    check("R9 tip off", levels_locked, 0);
  endtask

  initial begin
    rst = 1'b1;
    gate_sync = 0; gate_porch = 0; peak_white_n = 1;
    luma_code = 0; chroma_code = 0; luma_tc = 0; chroma_tc = 0;
    repeat (2) @(posedge clk);
    do_reset();
    t_reset();
    t_gain();
    t_clamp();
    t_peak();
    t_idle();
    t_overlap();
    t_format();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule